// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block is the slave end of an asynchronous parallel processor bus. An external host reads and writes a small internal register file through it. A static `mode` input picks one of two cycle styles. In the first, separate active-low read and write strobes mark the access. In the second, one active-low data strobe marks the access and a direction line chooses read (high) or write (low). A `width16` input picks a 16-bit or an 8-bit data bus. An `ale` input supports hosts that put the address and data on shared lines: while `ale` is high the address passes through, and once `ale` drops the captured address is held.

Every bus pin is brought into the system clock through a synchronizer. The block answers each access with an active-low ready that it drives only while the block is selected. Write data is committed when the write strobe is released. Event inputs set sticky status bits, and software clears each bit by writing a one to it. Status bits that are also enabled pull an active-low interrupt line low. When no enabled event is pending, that line either drives high or floats, as set by a control bit.

Register map (byte addresses): 0x0 scratch A, 0x2 scratch B, 0x4 event status, 0x6 event enable, 0x8 control (bit 0 = drive interrupt high when idle), 0xA identity constant. Every other address reads zero.

Top module: `hbus_regif`

## Requirements
- R1: An access exists only while `cs_n` is low. When `cs_n` is high, strobes have no effect, and `rdy_oe` is 0 whenever `cs_n` is high or `rst_n` is low.
- R2: With `mode`=0, `rd_ds_n` low is a read and `wr_rw_n` low is a write.
- R3: With `mode`=1, `rd_ds_n` is the data strobe for both directions. `wr_rw_n` high makes the access a read and `wr_rw_n` low makes it a write.
- R4: `rdy_n` reads 1 at the first three falling clock edges after a strobe falls. It reads 0 from the fourth falling edge on, and stays 0 until the strobe is released.
- R5: A write takes effect at the third rising clock edge after the strobe (or `cs_n`) is released. Address and data must stay valid for two clocks after the release.
- R6: While `ale` is high the address pins are used directly. When `ale` falls, the address is captured and held until `ale` rises again. The address must stay valid for two clocks after the fall. Tying `ale` high gives non-multiplexed operation.
- R7: With `width16`=1, the full 16-bit word is transferred and address bit 0 is ignored.
- R8: With `width16`=0, only `din[7:0]` is used. Address bit 0 = 0 selects the low byte and 1 selects the high byte. `dout[15:8]` reads 0.
- R9: Scratch registers reset to 0 and read back what was written. The identity register always reads `ID_VAL` (0x5A17) and ignores writes. Unmapped addresses read 0.
- R10: An event input that is high at a rising edge sets its status bit, and the bit stays set after the event drops. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a set and a clear arrive together, the set wins.
- R11: If any status bit is set while its enable bit is 1, `irq_oe`=1 and `irq_n`=0.
- R12: If no enabled bit is pending, `irq_n`=1 and `irq_oe` equals control bit 0. Reset clears the enables and that control bit, and `irq_oe` is 0 while reset is held.
- R13: `dout_oe` is 1 only during a synchronized read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_ds_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_rw_n | input | 1 | Write strobe (mode 0) or read/not-write (mode 1) |
| mode | input | 1 | Strobe style, static |
| width16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| ale | input | 1 | Address latch enable; tie high when unused |
| addr | input | AW | Byte address |
| din | input | 16 | Write data from host |
| ev_i | input | NEV | Event sources, active high |
| dout | output | 16 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| rdy_n | output | 1 | Ready level, active low |
| rdy_oe | output | 1 | Ready drive enable |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Interrupt drive enable |

## Verification
Two synchronizer stages put every bus result a fixed number of clocks after the pin change that causes it. Ready falls at the fourth falling edge after the strobe falls. A write is visible at the third rising edge after release, and so the interrupt pin reacts to a write to enable, status or control at that edge. The bench drives pins on falling edges and samples exactly there: it checks `rdy_n` at the third and fourth samples, and it checks the interrupt after a write at the second sample (still old value) and the third (new value). Read data is taken only once ready has been observed low.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   // word index of each register (byte address >> 1)
   typedef enum logic [2:0] {
      IDX_SCR_A = 3'd0,
      IDX_SCR_B = 3'd1,
      IDX_STAT  = 3'd2,
      IDX_EN    = 3'd3,
      IDX_CTRL  = 3'd4,
      IDX_ID    = 3'd5
   } reg_idx_e;

   function automatic logic [15:0] lane_merge(input logic [15:0] old_v,
                                              input logic [15:0] new_v,
                                              input logic [15:0] mask);
      return (old_v & ~mask) | (new_v & mask);
   endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[s] <= RST_VAL;
         else if (s == 0) pipe[s] <= d;
         else             pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale_s,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held <= '0;
      else if (ale_s) held <= addr_i;
   end

   assign addr_o = ale_s ? addr_i : held;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
   import hbus_pkg::*;
#(
   parameter int unsigned AW     = 4,
   parameter int unsigned NEV    = 4,
   parameter logic [15:0] ID_VAL = 16'h5A17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wide,
   input  logic [AW-1:0] waddr,
   input  logic [15:0]   wdat,
   input  logic [AW-2:0] ridx,
   output logic [15:0]   rword,
   input  logic [NEV-1:0] ev_i,
   output logic          irq_act,
   output logic          drv_hi
);
   localparam int unsigned IW = AW - 1;
   localparam logic [IW-1:0] I_SA = IW'(IDX_SCR_A);
   localparam logic [IW-1:0] I_SB = IW'(IDX_SCR_B);
   localparam logic [IW-1:0] I_ST = IW'(IDX_STAT);
   localparam logic [IW-1:0] I_EN = IW'(IDX_EN);
   localparam logic [IW-1:0] I_CT = IW'(IDX_CTRL);
   localparam logic [IW-1:0] I_ID = IW'(IDX_ID);

   logic [15:0]    scr_a, scr_b;
   logic [NEV-1:0] stat, en, clr;
   logic [1:0]     be;
   logic [15:0]    mask, wd;
   logic [IW-1:0]  widx;

   assign widx = waddr[AW-1:1];
   assign be   = wide ? 2'b11 : (waddr[0] ? 2'b10 : 2'b01);
   assign wd   = wide ? wdat : {wdat[7:0], wdat[7:0]};

   for (genvar l = 0; l < 2; l++) begin : g_lane
      assign mask[8*l +: 8] = {8{be[l]}};
   end

   assign clr = (we && widx == I_ST) ? NEV'(wd & mask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr_a  <= '0;
         scr_b  <= '0;
         stat   <= '0;
         en     <= '0;
         drv_hi <= 1'b0;
      end else begin
         stat <= (stat & ~clr) | ev_i;   // set wins over clear
         if (we) begin
            if (widx == I_SA) scr_a <= lane_merge(scr_a, wd, mask);
            if (widx == I_SB) scr_b <= lane_merge(scr_b, wd, mask);
            if (widx == I_EN) en    <= NEV'(lane_merge(16'(en), wd, mask));
            if (widx == I_CT && mask[0]) drv_hi <= wd[0];
         end
      end
   end

   always_comb begin
      rword = '0;
      if (ridx == I_SA) rword = scr_a;
      if (ridx == I_SB) rword = scr_b;
      if (ridx == I_ST) rword = 16'(stat);
      if (ridx == I_EN) rword = 16'(en);
      if (ridx == I_CT) rword = {15'd0, drv_hi};
      if (ridx == I_ID) rword = ID_VAL;
   end

   assign irq_act = |(stat & en);
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif #(
   parameter int unsigned AW          = 4,
   parameter int unsigned NEV         = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RDY_WAIT    = 2,
   parameter logic [15:0] ID_VAL      = 16'h5A17
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           rd_ds_n,
   input  logic           wr_rw_n,
   input  logic           mode,
   input  logic           width16,
   input  logic           ale,
   input  logic [AW-1:0]  addr,
   input  logic [15:0]    din,
   input  logic [NEV-1:0] ev_i,
   output logic [15:0]    dout,
   output logic           dout_oe,
   output logic           rdy_n,
   output logic           rdy_oe,
   output logic           irq_n,
   output logic           irq_oe
);
   localparam int unsigned WCW = $clog2(RDY_WAIT + 1);

   if (AW < 4) begin : g_bad_aw
      $error("hbus_regif: AW must be at least 4");
   end
   if (NEV < 1 || NEV > 16) begin : g_bad_nev
      $error("hbus_regif: NEV must be 1..16");
   end
   if (RDY_WAIT < 1) begin : g_bad_wait
      $error("hbus_regif: RDY_WAIT must be at least 1");
   end

   logic ale_s, cs_s, rs_s, ws_s;
   logic rd_act, wr_act, acc, wr_q, wr_commit, irq_act, drv_hi;
   logic [WCW-1:0] wcnt;
   logic [AW-1:0]  addr_eff, wadr;
   logic [15:0]    wdat, rword;

   hbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ale, cs_n, rd_ds_n, wr_rw_n}),
      .q({ale_s, cs_s, rs_s, ws_s})
   );

   hbus_addr_latch #(.AW(AW)) u_alat (
      .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .addr_i(addr), .addr_o(addr_eff)
   );

   // strobe decode: mode 1 = data strobe + direction, mode 0 = split strobes
   assign rd_act = !cs_s && (mode ? (!rs_s && ws_s)  : !rs_s);
   assign wr_act = !cs_s && (mode ? (!rs_s && !ws_s) : !ws_s);
   assign acc    = rd_act || wr_act;
   assign wr_commit = wr_q && !wr_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         wcnt <= WCW'(RDY_WAIT);
         wadr <= '0;
         wdat <= '0;
      end else begin
         wr_q <= wr_act;
         if (!acc)              wcnt <= WCW'(RDY_WAIT);
         else if (wcnt != '0)   wcnt <= wcnt - 1'b1;
         if (wr_act) begin
            wadr <= addr_eff;
            wdat <= din;
         end
      end
   end

   hbus_regfile #(.AW(AW), .NEV(NEV), .ID_VAL(ID_VAL)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(wr_commit), .wide(width16),
      .waddr(wadr), .wdat(wdat), .ridx(addr_eff[AW-1:1]), .rword(rword),
      .ev_i(ev_i), .irq_act(irq_act), .drv_hi(drv_hi)
   );

   assign dout_oe = rst_n && rd_act;
   assign dout    = !dout_oe ? 16'h0000 :
                    width16  ? rword :
                    {8'h00, (addr_eff[0] ? rword[15:8] : rword[7:0])};

   assign rdy_n  = !(acc && wcnt == '0);
   assign rdy_oe = rst_n && !cs_n;
   assign irq_n  = !irq_act;
   assign irq_oe = rst_n && (irq_act || drv_hi);
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
   parameter int unsigned RDY_WAIT = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       acc,
   input logic       commit,
   input logic       rdy_n,
   input logic       rdy_oe,
   input logic       irq_pend,
   input logic       irq_n,
   input logic       irq_oe,
   input logic       dout_oe,
   input logic       width16,
   input logic [7:0] dout_hi
);
   int unsigned acc_cyc;
   logic        any_commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cyc    <= 0;
         any_commit <= 1'b0;
      end else begin
         if (!acc)                  acc_cyc <= 0;
         else if (acc_cyc < RDY_WAIT) acc_cyc <= acc_cyc + 1;
         if (commit) any_commit <= 1'b1;
      end
   end

   p_rdy_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_oe && !rdy_n) |-> (acc_cyc >= RDY_WAIT));
   p_rdy_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc) |-> rdy_n);
   p_commit_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(acc));
   p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend |-> (irq_oe && !irq_n));
   p_irq_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !any_commit |-> !irq_oe);
   p_byte_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && !width16) |-> (dout_hi == 8'h00));
endmodule

bind hbus_regif hbus_regif_chk #(.RDY_WAIT(RDY_WAIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc(acc), .commit(wr_commit),
   .rdy_n(rdy_n), .rdy_oe(rdy_oe), .irq_pend(irq_act), .irq_n(irq_n),
   .irq_oe(irq_oe), .dout_oe(dout_oe), .width16(width16), .dout_hi(dout[15:8])
);

// File: tb/hbus_regif_tb.sv
module hbus_regif_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, cs_n, rd_ds_n, wr_rw_n, mode, width16, ale;
   logic [3:0]  addr, ev_i;
   logic [15:0] din, dout;
   logic        dout_oe, rdy_n, rdy_oe, irq_n, irq_oe;

   int total = 0;
   int bad   = 0;

   hbus_regif u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n),
      .mode(mode), .width16(width16), .ale(ale), .addr(addr), .din(din),
      .ev_i(ev_i), .dout(dout), .dout_oe(dout_oe), .rdy_n(rdy_n),
      .rdy_oe(rdy_oe), .irq_n(irq_n), .irq_oe(irq_oe)
   );

   typedef struct packed {
      logic        m;
      logic        w16;
      logic        wr;
      logic [3:0]  a;
      logic [15:0] d;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{1'b0, 1'b1, 1'b1, 4'h0, 16'h1234, 4'd2},  // R2 write split strobes
      '{1'b0, 1'b1, 1'b0, 4'h0, 16'h1234, 4'd2},  // R2 read back
      '{1'b1, 1'b1, 1'b1, 4'h2, 16'hBEEF, 4'd3},  // R3 data strobe write
      '{1'b1, 1'b1, 1'b0, 4'h2, 16'hBEEF, 4'd3},  // R3 data strobe read
      '{1'b0, 1'b1, 1'b0, 4'h1, 16'h1234, 4'd7},  // R7 odd address ignored
      '{1'b0, 1'b0, 1'b1, 4'h1, 16'h77AB, 4'd8},  // R8 high byte write
      '{1'b0, 1'b1, 1'b0, 4'h0, 16'hAB34, 4'd8},  // R8 low byte kept
      '{1'b1, 1'b0, 1'b0, 4'h0, 16'h0034, 4'd8},  // R8 byte read low
      '{1'b1, 1'b0, 1'b0, 4'h3, 16'h00BE, 4'd8},  // R8 byte read high
      '{1'b0, 1'b1, 1'b0, 4'hA, 16'h5A17, 4'd9},  // R9 identity
      '{1'b0, 1'b1, 1'b1, 4'hA, 16'h0000, 4'd9},  // R9 write to identity
      '{1'b0, 1'b1, 1'b0, 4'hA, 16'h5A17, 4'd9},  // R9 unchanged
      '{1'b0, 1'b1, 1'b0, 4'hE, 16'h0000, 4'd9}   // R9 unmapped
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_rdy();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (rdy_n === 1'b0) return;
      end
      chk("R4 ready never low", 32'(rdy_n), 32'd0);
   endtask

   task automatic bus_wr(input logic m, input logic w, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      mode = m; width16 = w; addr = a; din = d;
      cs_n = 1'b0;
      if (m) begin wr_rw_n = 1'b0; rd_ds_n = 1'b0; end
      else   wr_rw_n = 1'b0;
      wait_rdy();
      cs_n = 1'b1;
      if (m) rd_ds_n = 1'b1; else wr_rw_n = 1'b1;
      repeat (4) @(negedge clk);
      wr_rw_n = 1'b1;
   endtask

   task automatic bus_rd(input logic m, input logic w, input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      mode = m; width16 = w; addr = a;
      cs_n = 1'b0; wr_rw_n = 1'b1; rd_ds_n = 1'b0;
      wait_rdy();
      d = dout;
      cs_n = 1'b1; rd_ds_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      rst_n = 1'b0; cs_n = 1'b0; rd_ds_n = 1'b1; wr_rw_n = 1'b1;
      mode = 1'b0; width16 = 1'b1; ale = 1'b1; addr = '0; din = '0; ev_i = '0;
      repeat (3) @(negedge clk);
      // reset state: R1 ready undriven even when selected, R12 interrupt undriven
      chk("R1 rdy_oe in reset", 32'(rdy_oe), 32'd0);
      chk("R12 irq_oe in reset", 32'(irq_oe), 32'd0);
      chk("R13 dout_oe in reset", 32'(dout_oe), 32'd0);
      cs_n = 1'b1;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 rdy_oe deselected", 32'(rdy_oe), 32'd0);
      chk("R13 dout_oe idle", 32'(dout_oe), 32'd0);
      bus_rd(1'b0, 1'b1, 4'h0, rd);
      chk("R9 scratch reset", 32'(rd), 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VT[i].wr) bus_wr(VT[i].m, VT[i].w16, VT[i].a, VT[i].d);
         else begin
            bus_rd(VT[i].m, VT[i].w16, VT[i].a, rd);
            chk($sformatf("vector %0d R%0d", i, VT[i].req), 32'(rd), 32'(VT[i].d));
         end
      end

      // R4: ready timing
      @(negedge clk);
      mode = 1'b0; width16 = 1'b1; addr = 4'h0; cs_n = 1'b0; rd_ds_n = 1'b0;
      @(negedge clk);
      chk("R1 rdy_oe selected", 32'(rdy_oe), 32'd1);
      chk("R13 dout_oe before sync", 32'(dout_oe), 32'd0);
      @(negedge clk); @(negedge clk);
      chk("R4 rdy_n third sample", 32'(rdy_n), 32'd1);
      @(negedge clk);
      chk("R4 rdy_n fourth sample", 32'(rdy_n), 32'd0);
      chk("R13 dout_oe reading", 32'(dout_oe), 32'd1);
      repeat (3) @(negedge clk);
      chk("R4 rdy_n held", 32'(rdy_n), 32'd0);
      cs_n = 1'b1; rd_ds_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10/R11/R12 interrupt path
      bus_wr(1'b0, 1'b1, 4'h6, 16'h0001);
      chk("R12 float no pending", 32'(irq_oe), 32'd0);
      ev_i = 4'b0011;
      @(negedge clk);
      ev_i = 4'b0000;
      @(negedge clk);
      chk("R11 irq_oe pending", 32'(irq_oe), 32'd1);
      chk("R11 irq_n pending", 32'(irq_n), 32'd0);
      bus_rd(1'b0, 1'b1, 4'h4, rd);
      chk("R10 sticky status", 32'(rd), 32'h3);
      bus_wr(1'b0, 1'b1, 4'h4, 16'h0002);
      bus_rd(1'b0, 1'b1, 4'h4, rd);
      chk("R10 one-to-clear", 32'(rd), 32'h1);
      chk("R11 still pending", 32'(irq_n), 32'd0);
      bus_wr(1'b1, 1'b1, 4'h4, 16'h0001);
      chk("R12 float after clear", 32'(irq_oe), 32'd0);
      bus_wr(1'b0, 1'b1, 4'h8, 16'h0001);
      chk("R12 drive high oe", 32'(irq_oe), 32'd1);
      chk("R12 drive high level", 32'(irq_n), 32'd1);

      // R10 set wins: event held high across a clearing write
      ev_i = 4'b0001;
      bus_wr(1'b0, 1'b1, 4'h4, 16'h0001);
      ev_i = 4'b0000;
      @(negedge clk);
      chk("R10 set wins over clear", 32'(irq_n), 32'd0);

      // R5: commit timing, observed on the interrupt pin
      @(negedge clk);
      mode = 1'b0; width16 = 1'b1; addr = 4'h4; din = 16'h0001;
      cs_n = 1'b0; wr_rw_n = 1'b0;
      wait_rdy();
      cs_n = 1'b1; wr_rw_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R5 not yet committed", 32'(irq_n), 32'd0);
      @(negedge clk);
      chk("R5 committed", 32'(irq_n), 32'd1);
      repeat (3) @(negedge clk);

      // R1: strobes ignored while deselected
      @(negedge clk);
      addr = 4'h0; din = 16'hFFFF; wr_rw_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 rdy_oe stays off", 32'(rdy_oe), 32'd0);
      repeat (3) @(negedge clk);
      wr_rw_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_rd(1'b0, 1'b1, 4'h0, rd);
      chk("R1 write ignored", 32'(rd), 32'hAB34);

      // R6: multiplexed address latch
      @(negedge clk);
      addr = 4'h2; ale = 1'b1;
      repeat (3) @(negedge clk);
      ale = 1'b0;
      repeat (3) @(negedge clk);
      addr = 4'h0;
      bus_rd(1'b0, 1'b1, 4'h0, rd);
      chk("R6 latched address", 32'(rd), 32'hBEEF);
      ale = 1'b1;
      repeat (3) @(negedge clk);
      bus_rd(1'b0, 1'b1, 4'h0, rd);
      chk("R6 pass-through", 32'(rd), 32'hAB34);

      // R12: reset clears enables and control, interrupt undriven in reset
      @(negedge clk);
      rst_n = 1'b0; cs_n = 1'b0;
      @(negedge clk);
      chk("R12 irq_oe during reset", 32'(irq_oe), 32'd0);
      chk("R1 rdy_oe during reset", 32'(rdy_oe), 32'd0);
      cs_n = 1'b1; rst_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_rd(1'b0, 1'b1, 4'h6, rd);
      chk("R12 enables cleared", 32'(rd), 32'h0);
      bus_rd(1'b0, 1'b1, 4'h8, rd);
      chk("R12 control cleared", 32'(rd), 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule